// File: doc/BRIEF.md
# Reference Sync Genlock Selector

This block sits beside a local video sync generator and decides whether that generator free-runs on its own timebase or follows an external composite sync. It watches a clean, active-low reference sync signal and measures the spacing of its falling edges in master clocks. When enough edges arrive at line or half-line spacing, it declares the reference present and, in automatic mode, enters genlock. While in genlock it emits a one-clock horizontal reset for every line-aligned reference edge. It also emits a one-clock vertical reset once per field.

The vertical reset can be placed at one of two points. It can go at the first equalizing pulse, which is the first half-line-spaced edge after a run of full lines. It can instead go at the first broad vertical sync pulse, which is seen as the reference staying low for more than a quarter of a line. If valid edges stop arriving for several lines, the block drops back to the local timebase. A two-bit override can pin the mode to either choice.

Top module: `gl_genlock_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `genlock`, `h_reset` and `v_reset` are all low when `mode_force` selects automatic mode.
- R2: A falling edge is valid when its spacing from the previous falling edge is within ±TOL_CLKS (2) of LINE_CLKS (64) or of LINE_CLKS/2 (32). After 8 consecutive valid spacings the reference counts as present. In automatic mode `genlock` then goes high.
- R3: An edge whose spacing is outside both tolerance windows clears the run of valid spacings. A train spaced outside the windows, or a run broken before reaching 8, never brings up `genlock` in automatic mode.
- R4: After LOSS_LINES × LINE_CLKS (256) clocks with no valid edge, the reference counts as absent. In automatic mode `genlock` returns low.
- R5: `mode_force` encoding: 2'b00 and 2'b11 mean automatic, 2'b01 forces genlock, and 2'b10 forces stand-alone. `genlock` follows the selection one clock later.
- R6: While in genlock, each reference falling edge that lands one line (±TOL_CLKS) after the previous line-aligned edge produces a one-cycle `h_reset`. Half-line edges between lines produce none.
- R7: With `vres_at_vsync` = 0, `v_reset` pulses once per field. It fires at the first half-line-spaced edge after a line-spaced, line-aligned edge.
- R8: With `vres_at_vsync` = 1, `v_reset` pulses once per field. It fires when the reference has stayed low for more than LINE_CLKS/4 (16) clocks during the first broad pulse.
- R9: `v_reset` is a single-cycle pulse and is only produced while `genlock` is high. In forced stand-alone mode, a full vertical interval produces no `h_reset` and no `v_reset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sync_n | input | 1 | Reference composite sync, active low, asynchronous to clk |
| mode_force | input | 2 | Mode override: 00/11 automatic, 01 genlock, 10 stand-alone |
| vres_at_vsync | input | 1 | Vertical reset point: 0 first equalizing pulse, 1 first broad pulse |
| genlock | output | 1 | High while the local generator follows the reference |
| h_reset | output | 1 | One-cycle horizontal counter reset |
| v_reset | output | 1 | One-cycle vertical counter reset |

## Verification
The bound checker watches every cycle for three things. It confirms that both reset outputs are single-cycle and appear only when the previous cycle was in genlock. It also confirms that a forced mode is reflected on `genlock` one clock later.

The bench's scenarios cover what needs a sequence of edges:
- the lock after eight valid spacings and the tolerance edges at 66 and 67 clocks;
- a lock run broken by one bad spacing;
- the fall-back after four silent lines;
- the number of horizontal resets for line and half-line trains;
- exactly one vertical reset per synthetic field at either selected point.

// File: rtl/gl_pkg.sv
package gl_pkg;
   typedef enum logic [1:0] {
      GL_AUTO       = 2'b00,
      GL_FORCE_LOCK = 2'b01,
      GL_FORCE_FREE = 2'b10,
      GL_AUTO_ALT   = 2'b11
   } gl_force_e;
endpackage

// File: rtl/gl_ref_sync.sv
// Synchroniser chain, falling-edge detect and low-time measurement.
module gl_ref_sync #(
   parameter int STAGES  = 2,
   parameter int QUARTER = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_n,
   output logic fall_o,
   output logic broad_o
);
   localparam int LW = $clog2(QUARTER + 2);

   logic [STAGES-1:0] sh_q;
   logic              s_d_q;
   logic [LW-1:0]     low_q;
   logic              s_now;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gl_ref_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '1;
         s_d_q <= 1'b1;
      end else begin
         sh_q  <= {sh_q[STAGES-2:0], ref_n};
         s_d_q <= sh_q[STAGES-1];
      end
   end

   assign s_now  = sh_q[STAGES-1];
   assign fall_o = s_d_q & ~s_now;

   // low-time counter saturates one above the quarter-line threshold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
      end else if (s_now) begin
         low_q <= '0;
      end else if (low_q != LW'(QUARTER + 1)) begin
         low_q <= low_q + 1'b1;
      end
   end

   assign broad_o = ~s_now && (low_q == LW'(QUARTER));
endmodule

// File: rtl/gl_interval.sv
// Classifies falling-edge spacing as line, half-line or bad, and tracks line alignment.
module gl_interval #(
   parameter int LINE = 64,
   parameter int TOL  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_i,
   output logic valid_o,
   output logic bad_o,
   output logic half_o,
   output logic aligned_o,
   output logic arm_o
);
   localparam int HALF = LINE / 2;
   localparam int SAT  = 2 * LINE;
   localparam int CW   = $clog2(SAT + 1);

   logic [CW-1:0] since_edge_q;
   logic [CW-1:0] since_line_q;
   logic          is_line, is_half, near_line, overdue;

   function automatic logic near(input logic [CW-1:0] c, input int tgt);
      return (int'(c) >= tgt - TOL) && (int'(c) <= tgt + TOL);
   endfunction

   assign is_line   = near(since_edge_q, LINE);
   assign is_half   = near(since_edge_q, HALF);
   assign near_line = near(since_line_q, LINE);
   assign overdue   = int'(since_line_q) > LINE + TOL;

   assign valid_o   = fall_i & (is_line | is_half);
   assign bad_o     = fall_i & ~(is_line | is_half);
   assign half_o    = fall_i & is_half;
   assign aligned_o = fall_i & near_line;
   assign arm_o     = fall_i & near_line & is_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_edge_q <= '0;
      end else if (fall_i) begin
         since_edge_q <= CW'(1);
      end else if (since_edge_q != CW'(SAT)) begin
         since_edge_q <= since_edge_q + 1'b1;
      end
   end

   // line phase restarts on an aligned edge or on the first edge after it went stale
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_line_q <= '0;
      end else if (fall_i && (near_line || overdue)) begin
         since_line_q <= CW'(1);
      end else if (since_line_q != CW'(SAT)) begin
         since_line_q <= since_line_q + 1'b1;
      end
   end
endmodule

// File: rtl/gl_lock.sv
// Presence decision: consecutive valid spacings to acquire, silence timer to release.
module gl_lock #(
   parameter int LOCK_CNT  = 8,
   parameter int LOSS_CLKS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid_i,
   input  logic bad_i,
   output logic present_o
);
   localparam int SW  = $clog2(LOCK_CNT + 1);
   localparam int LCW = $clog2(LOSS_CLKS + 1);

   logic [SW-1:0]  streak_q;
   logic [LCW-1:0] quiet_q;
   logic           expired;

   assign expired = (quiet_q == LCW'(LOSS_CLKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         streak_q  <= '0;
         quiet_q   <= '0;
         present_o <= 1'b0;
      end else if (valid_i) begin
         quiet_q <= '0;
         if (streak_q != SW'(LOCK_CNT)) streak_q <= streak_q + 1'b1;
         if (streak_q == SW'(LOCK_CNT - 1)) present_o <= 1'b1;
      end else begin
         if (bad_i) streak_q <= '0;
         if (expired) begin
            present_o <= 1'b0;
            streak_q  <= '0;
         end else begin
            quiet_q <= quiet_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/gl_genlock_sel.sv
module gl_genlock_sel
   import gl_pkg::*;
#(
   parameter int LINE_CLKS   = 64,
   parameter int TOL_CLKS    = 2,
   parameter int LOCK_CNT    = 8,
   parameter int LOSS_LINES  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_sync_n,
   input  logic [1:0] mode_force,
   input  logic       vres_at_vsync,
   output logic       genlock,
   output logic       h_reset,
   output logic       v_reset
);
   localparam int QUARTER   = LINE_CLKS / 4;
   localparam int LOSS_CLKS = LOSS_LINES * LINE_CLKS;

   generate
      if (LINE_CLKS < 16 || (LINE_CLKS % 4) != 0) begin : g_bad_line
         $error("gl_genlock_sel: LINE_CLKS must be a multiple of 4, at least 16");
      end
      if (2 * TOL_CLKS >= QUARTER) begin : g_bad_tol
         $error("gl_genlock_sel: tolerance windows would overlap");
      end
      if (LOCK_CNT < 1 || LOSS_LINES < 1) begin : g_bad_counts
         $error("gl_genlock_sel: LOCK_CNT and LOSS_LINES must be positive");
      end
   endgenerate

   logic fall, broad, valid_e, bad_e, half_e, aligned_e, arm_e, present;
   logic armed_q, v_event, genlock_d;
   gl_force_e force_sel;

   gl_ref_sync #(.STAGES(SYNC_STAGES), .QUARTER(QUARTER)) u_sync (
      .clk(clk), .rst_n(rst_n), .ref_n(ref_sync_n),
      .fall_o(fall), .broad_o(broad)
   );

   gl_interval #(.LINE(LINE_CLKS), .TOL(TOL_CLKS)) u_ival (
      .clk(clk), .rst_n(rst_n), .fall_i(fall),
      .valid_o(valid_e), .bad_o(bad_e), .half_o(half_e),
      .aligned_o(aligned_e), .arm_o(arm_e)
   );

   gl_lock #(.LOCK_CNT(LOCK_CNT), .LOSS_CLKS(LOSS_CLKS)) u_lock (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_e), .bad_i(bad_e),
      .present_o(present)
   );

   assign force_sel = gl_force_e'(mode_force);

   always_comb begin
      unique case (force_sel)
         GL_FORCE_LOCK: genlock_d = 1'b1;
         GL_FORCE_FREE: genlock_d = 1'b0;
         default:       genlock_d = present;
      endcase
   end

   // vertical point: half-line edge after arming, or first broad pulse after arming
   assign v_event = armed_q & (vres_at_vsync ? broad : half_e);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         genlock <= 1'b0;
         h_reset <= 1'b0;
         v_reset <= 1'b0;
      end else begin
         genlock <= genlock_d;
         h_reset <= aligned_e & genlock;
         v_reset <= v_event & genlock;
         if (arm_e)        armed_q <= 1'b1;
         else if (v_event) armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/gl_genlock_sel_chk.sv
module gl_genlock_sel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_force,
   input logic       genlock,
   input logic       h_reset,
   input logic       v_reset
);
   a_r5_force_lock: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_force) == 2'b01) |-> genlock);

   a_r5_force_free: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_force) == 2'b10) |-> !genlock);

   a_r6_h_single: assert property (@(posedge clk) disable iff (!rst_n)
      h_reset |=> !h_reset);

   a_r6_h_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      h_reset |-> $past(genlock));

   a_r9_v_single: assert property (@(posedge clk) disable iff (!rst_n)
      v_reset |=> !v_reset);

   a_r9_v_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      v_reset |-> $past(genlock));
endmodule

bind gl_genlock_sel gl_genlock_sel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mode_force(mode_force),
   .genlock(genlock), .h_reset(h_reset), .v_reset(v_reset)
);

// File: tb/gl_genlock_sel_bench.sv
module gl_genlock_sel_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LINE = 64;
   localparam int NV = 9;
   // force, pulses, spacing, expected genlock, expected h_reset count
   localparam int VEC [NV][5] = '{
      '{0, 12, 64, 1, 3},   // R2 R6 nominal line rate
      '{0, 12, 66, 1, 3},   // R2 upper tolerance
      '{0, 12, 67, 0, 0},   // R3 outside window
      '{0, 12, 32, 1, 1},   // R2 R6 half-line train
      '{1,  3, 64, 1, 2},   // R5 forced genlock
      '{2, 12, 64, 0, 0},   // R5 forced stand-alone
      '{0,  9, 64, 1, 0},   // R2 exactly eight spacings
      '{0,  8, 64, 0, 0},   // R2 seven spacings
      '{3, 12, 64, 1, 3}    // R5 alternate automatic code
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_sync_n = 1'b1;
   logic [1:0] mode_force = 2'b00;
   logic vres_at_vsync = 1'b0;
   logic genlock, h_reset, v_reset;

   int checks = 0, fails = 0;
   int hcnt = 0, vcnt = 0, cyc = 0, vcyc = 0;
   bit done = 1'b0;

   gl_genlock_sel u_gl_genlock_sel (
      .clk(clk), .rst_n(rst_n), .ref_sync_n(ref_sync_n),
      .mode_force(mode_force), .vres_at_vsync(vres_at_vsync),
      .genlock(genlock), .h_reset(h_reset), .v_reset(v_reset)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (h_reset) hcnt <= hcnt + 1;
      if (v_reset) begin
         vcnt <= vcnt + 1;
         vcyc <= cyc;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input int frc, input bit vsel);
      @(negedge clk);
      rst_n = 1'b0;
      ref_sync_n = 1'b1;
      mode_force = 2'(frc);
      vres_at_vsync = vsel;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
   endtask

   task automatic pulses(input int n, input int p, input int w);
      for (int k = 0; k < n; k++) begin
         for (int i = 0; i < p; i++) begin
            ref_sync_n = (i < w) ? 1'b0 : 1'b1;
            @(negedge clk);
         end
      end
   endtask

   task automatic field(output int bstart);
      pulses(6, 32, 2);
      bstart = cyc;
      pulses(6, 32, 28);
      pulses(6, 32, 2);
      pulses(4, 64, 4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int h0, v0, bs;
      // R1 reset state
      @(negedge clk);
      chk(!genlock && !h_reset && !v_reset, "R1 outputs low in reset", int'(genlock), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!genlock && !h_reset && !v_reset, "R1 outputs low after reset", int'(genlock), 0);

      for (int i = 0; i < NV; i++) begin
         do_reset(VEC[i][0], 1'b0);
         h0 = hcnt;
         pulses(VEC[i][1], VEC[i][2], 4);
         chk(int'(genlock) == VEC[i][3], $sformatf("R2/R3/R5 genlock vector %0d", i),
             int'(genlock), VEC[i][3]);
         chk(hcnt - h0 == VEC[i][4], $sformatf("R6 h_reset count vector %0d", i),
             hcnt - h0, VEC[i][4]);
      end

      // R3 broken run: 7 valid spacings, one bad, then 6 valid
      do_reset(0, 1'b0);
      pulses(7, 64, 4);
      pulses(1, 50, 4);
      pulses(7, 64, 4);
      chk(!genlock, "R3 broken run stays stand-alone", int'(genlock), 0);

      // R4 loss of reference
      do_reset(0, 1'b0);
      pulses(12, 64, 4);
      repeat (150) @(negedge clk);
      chk(genlock, "R4 still locked before timeout", int'(genlock), 1);
      repeat (60) @(negedge clk);
      chk(!genlock, "R4 fallback after silence", int'(genlock), 0);

      // R7 vertical reset at first equalizing pulse, two fields
      do_reset(0, 1'b0);
      pulses(12, 64, 4);
      v0 = vcnt;
      field(bs);
      chk(vcnt - v0 == 1, "R7 one v_reset first field", vcnt - v0, 1);
      field(bs);
      chk(vcnt - v0 == 2, "R7 one v_reset per field", vcnt - v0, 2);
      chk(genlock, "R2 lock held through vertical interval", int'(genlock), 1);

      // R8 vertical reset at first broad pulse
      do_reset(0, 1'b1);
      pulses(12, 64, 4);
      v0 = vcnt;
      field(bs);
      chk(vcnt - v0 == 1, "R8 one v_reset first field", vcnt - v0, 1);
      chk(vcyc - bs >= 17 && vcyc - bs <= 22, "R8 v_reset after quarter-line low",
          vcyc - bs, 19);
      field(bs);
      chk(vcnt - v0 == 2, "R8 one v_reset per field", vcnt - v0, 2);

      // R9 no resets in forced stand-alone
      do_reset(2, 1'b1);
      pulses(12, 64, 4);
      v0 = vcnt;
      h0 = hcnt;
      field(bs);
      chk(vcnt - v0 == 0, "R9 no v_reset when stand-alone", vcnt - v0, 0);
      chk(hcnt - h0 == 0, "R9 no h_reset when stand-alone", hcnt - h0, 0);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule